// File: doc/BRIEF.md
# Framed Serial Management Slave

This block is a slave-only management port on a four-wire serial link: a serial clock, serial data in, serial data out and an active-low framing strobe. All three inputs are brought into the local system clock domain through a synchronizer, and edges are found there. The block never starts a transfer. While the strobe is low, the master first sends a command: a start bit, then a write/read flag, then a 6-bit chain address. A data phase of any length follows. Read data leaves the block MSB first on the serial output. Write data arrives MSB first and is committed when the strobe rises.

Three chains are implemented. The first is a 16-bit read-only identification word at address 0. The second is a generic read/write chain. The third is an impedance chain whose update is guarded: the write raises a STOP output, the new value is applied on the following strobe low pulse while STOP is held, and STOP is released on the next strobe rise. A sticky status flag reports any strobe high or low period shorter than a minimum number of system clocks.

The framing state machine has six states. IDLE is entered whenever the strobe is high. HUNT skips zeros until the start bit. CMD collects seven command bits. TURN waits for the falling serial clock edge that loads read data. READ shifts data out. WRITE shifts data in. Its transitions are IDLE->HUNT on a strobe low, HUNT->CMD on a sampled 1, CMD->TURN on the seventh command bit, TURN->READ or TURN->WRITE on a falling serial clock edge, and any state->IDLE on a strobe high. Reaching IDLE from WRITE commits the write. The impedance guard has three states. GIDLE goes to HOLD on an impedance commit. HOLD goes to APPLIED on a strobe fall, which loads the value. APPLIED goes to GIDLE on a strobe rise.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After reset, ser_dout, stop_hold and pulse_short are 0 and imp_value equals the reset value IMP_RESET (default 0).
- R2: While the strobe is low, zero bits sampled on rising serial clock edges are skipped until the first 1, which is the start bit. The next seven bits are the flag (1 = write, 0 = read) and then address bits 5 down to 0.
- R3: On a read, the addressed chain appears on ser_dout MSB first. The first bit is valid before the rising edge that follows the command, and each later falling serial clock edge advances one bit. Bits beyond the chain width read as 0, and ser_din is ignored.
- R4: Address 0 reads as the 16-bit ID_VALUE (default 16'h0610), and writes to it are discarded.
- R5: During a write data phase, ser_dout stays 0. The addressed chain changes only on the strobe rise that ends the frame, and it keeps the last W bits shifted in.
- R6: The generic chain at GEN_ADDR (default 1, GEN_W = 16 bits) reads back the last value written.
- R7: Addresses other than 0, GEN_ADDR and IMP_ADDR read as all zeros, and writes to them change no chain.
- R8: A strobe rise that comes before all eight command bits (counting the start bit) have been received aborts the frame with no chain change.
- R9: A write to the impedance chain at IMP_ADDR (default 2, IMP_W = 8 bits) raises stop_hold at its strobe rise and leaves imp_value unchanged. The next strobe fall loads imp_value while stop_hold stays 1. The strobe rise after that clears stop_hold.
- R10: stop_hold rises only after an impedance write. Writes to any other address leave it 0.
- R11: pulse_short is set when a strobe high or low period is shorter than MIN_PULSE_CYC system clocks (default 16). Once set, it stays 1 until reset.
- R12: ser_dout changes only after a detected falling serial clock edge, or when the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the master |
| ser_din | input | 1 | Serial data into the block |
| ser_stb_n | input | 1 | Active-low frame strobe |
| ser_dout | output | 1 | Serial data out, always driven |
| stop_hold | output | 1 | Holds the link halted during an impedance update |
| imp_value | output | IMP_W | Applied impedance setting |
| pulse_short | output | 1 | Sticky flag for a strobe period below the minimum |

## Verification
A wrong framing state shows on the next read as a shifted or zero word on ser_dout. An off-by-one in the command count shifts the address, so the master gets another chain's contents within one frame. A wrong guard state shows as stop_hold staying high, or as imp_value moving outside a STOP window, within one strobe edge. A lost write appears on the next read-back, and a stray commit appears as a changed value after an aborted or unused-address frame. Timing-flag errors show as pulse_short rising on a legal pulse or staying low after a short one, within a few system clocks of the strobe edge.

// File: rtl/mss_pkg.sv
package mss_pkg;
    localparam int CMD_BITS = 7;
    localparam int ADDR_W   = 6;

    typedef enum logic [2:0] {
        F_IDLE,
        F_HUNT,
        F_CMD,
        F_TURN,
        F_READ,
        F_WRITE
    } frame_state_e;

    typedef enum logic [1:0] {
        G_IDLE,
        G_HOLD,
        G_APPLIED
    } guard_state_e;
endpackage

// File: rtl/mss_sync.sv
module mss_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_async,
    output logic [WIDTH-1:0] out_sync
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q[0] <= in_async;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign out_sync = stage_q[STAGES-1];
endmodule

// File: rtl/mss_pulse_check.sv
module mss_pulse_check #(
    parameter int MIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_rise,
    input  logic stb_fall,
    output logic short_o
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

    logic [CW-1:0] len_q;
    logic          edge_seen;

    assign edge_seen = stb_rise | stb_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= LIMIT;
            short_o <= 1'b0;
        end else if (edge_seen) begin
            if (len_q < LIMIT) short_o <= 1'b1;
            len_q <= CW'(1);
        end else if (len_q < LIMIT) begin
            len_q <= len_q + CW'(1);
        end
    end

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(short_o) |-> short_o);

    assert_flag_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_o) |-> $past(stb_rise || stb_fall));
endmodule

// File: rtl/mss_frame.sv
module mss_frame
    import mss_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_s,
    input  logic              stb_low,
    input  logic              stb_rise,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              dout_o
);
    frame_state_e          state_q, state_d;
    logic [2:0]            cnt_q;
    logic [CMD_BITS-1:0]   cmd_q;
    logic [DATA_W-1:0]     in_q;
    logic [DATA_W-1:0]     out_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!stb_low) begin
            state_d = F_IDLE;
        end else begin
            unique case (state_q)
                F_IDLE:  state_d = F_HUNT;
                F_HUNT:  if (sclk_rise && din_s) state_d = F_CMD;
                F_CMD:   if (sclk_rise && cnt_q == 3'(CMD_BITS - 1)) state_d = F_TURN;
                F_TURN:  if (sclk_fall) state_d = cmd_q[CMD_BITS-1] ? F_WRITE : F_READ;
                F_READ:  state_d = F_READ;
                F_WRITE: state_d = F_WRITE;
                default: state_d = F_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmd_q <= '0;
            in_q  <= '0;
            out_q <= '0;
        end else if (!stb_low) begin
            cnt_q <= '0;
            out_q <= '0;
        end else begin
            case (state_q)
                F_HUNT: begin
                    cnt_q <= '0;
                    in_q  <= '0;
                end
                F_CMD: if (sclk_rise) begin
                    cmd_q <= {cmd_q[CMD_BITS-2:0], din_s};
                    cnt_q <= cnt_q + 3'd1;
                end
                F_TURN:  if (sclk_fall && !cmd_q[CMD_BITS-1]) out_q <= rd_data;
                F_READ:  if (sclk_fall) out_q <= {out_q[DATA_W-2:0], 1'b0};
                F_WRITE: if (sclk_rise) in_q <= {in_q[DATA_W-2:0], din_s};
                default: ;
            endcase
        end
    end

    assign addr_o   = cmd_q[ADDR_W-1:0];
    assign commit_o = (state_q == F_WRITE) && stb_rise;
    assign wdata_o  = in_q;
    assign dout_o   = out_q[DATA_W-1];

    assert_dout_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_o != $past(dout_o)) |-> ($past(sclk_fall) || $past(!stb_low)));

    assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_WRITE) |-> !dout_o);
endmodule

// File: rtl/mss_imp_guard.sv
module mss_imp_guard
    import mss_pkg::*;
#(
    parameter int             IMP_W     = 8,
    parameter logic [IMP_W-1:0] IMP_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [IMP_W-1:0] wr_val,
    input  logic             stb_rise,
    input  logic             stb_fall,
    output logic             stop_o,
    output logic [IMP_W-1:0] imp_o
);
    guard_state_e     state_q, state_d;
    logic [IMP_W-1:0] pend_q;
    logic [IMP_W-1:0] imp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= G_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_IDLE:    if (wr_req)   state_d = G_HOLD;
            G_HOLD:    if (stb_fall) state_d = G_APPLIED;
            G_APPLIED: if (stb_rise) state_d = G_IDLE;
            default:   state_d = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= IMP_RESET;
            imp_q  <= IMP_RESET;
        end else begin
            if (state_q == G_IDLE && wr_req)   pend_q <= wr_val;
            if (state_q == G_HOLD && stb_fall) imp_q  <= pend_q;
        end
    end

    always_comb begin
        stop_o = (state_q != G_IDLE);
        imp_o  = imp_q;
    end

    assert_stop_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_o) |-> $past(wr_req));

    assert_imp_under_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (imp_o != $past(imp_o)) |-> ($past(stop_o) && $past(stb_fall)));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_o) |-> $past(stb_rise));
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
    import mss_pkg::*;
#(
    parameter logic [15:0]      ID_VALUE      = 16'h0610,
    parameter int               GEN_W         = 16,
    parameter logic [5:0]       GEN_ADDR      = 6'd1,
    parameter int               IMP_W         = 8,
    parameter logic [5:0]       IMP_ADDR      = 6'd2,
    parameter logic [IMP_W-1:0] IMP_RESET     = '0,
    parameter int               MIN_PULSE_CYC = 16,
    parameter int               SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_din,
    input  logic             ser_stb_n,
    output logic             ser_dout,
    output logic             stop_hold,
    output logic [IMP_W-1:0] imp_value,
    output logic             pulse_short
);
    localparam int ID_W   = 16;
    localparam int W_A    = (GEN_W > ID_W) ? GEN_W : ID_W;
    localparam int DATA_W = (IMP_W > W_A) ? IMP_W : W_A;

    logic [2:0]        lvl;
    logic [1:0]        prev_q;
    logic              sclk_rise, sclk_fall, stb_rise, stb_fall;
    logic [ADDR_W-1:0] addr;
    logic              commit;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_data;
    logic [GEN_W-1:0]  gen_q;

    mss_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_async ({ser_stb_n, ser_din, ser_clk}),
        .out_sync (lvl)
    );

    // edge detection on serial clock (bit 0) and strobe (bit 1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b10;
        else        prev_q <= {lvl[2], lvl[0]};
    end

    assign sclk_rise = lvl[0] & ~prev_q[0];
    assign sclk_fall = ~lvl[0] & prev_q[0];
    assign stb_rise  = lvl[2] & ~prev_q[1];
    assign stb_fall  = ~lvl[2] & prev_q[1];

    mss_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (lvl[1]),
        .stb_low   (~lvl[2]),
        .stb_rise  (stb_rise),
        .rd_data   (rd_data),
        .addr_o    (addr),
        .commit_o  (commit),
        .wdata_o   (wdata),
        .dout_o    (ser_dout)
    );

    // chain read selection, left-aligned so the chain MSB leaves first
    always_comb begin
        rd_data = '0;
        if (addr == 6'd0)          rd_data[DATA_W-1 -: ID_W]  = ID_VALUE;
        else if (addr == GEN_ADDR) rd_data[DATA_W-1 -: GEN_W] = gen_q;
        else if (addr == IMP_ADDR) rd_data[DATA_W-1 -: IMP_W] = imp_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        gen_q <= '0;
        else if (commit && addr == GEN_ADDR) gen_q <= wdata[GEN_W-1:0];
    end

    mss_imp_guard #(.IMP_W(IMP_W), .IMP_RESET(IMP_RESET)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (commit && addr == IMP_ADDR),
        .wr_val   (wdata[IMP_W-1:0]),
        .stb_rise (stb_rise),
        .stb_fall (stb_fall),
        .stop_o   (stop_hold),
        .imp_o    (imp_value)
    );

    mss_pulse_check #(.MIN_CYC(MIN_PULSE_CYC)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_rise (stb_rise),
        .stb_fall (stb_fall),
        .short_o  (pulse_short)
    );

    assert_gen_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q != $past(gen_q)) |-> $past(stb_rise));
endmodule

// File: tb/mgmt_serial_slave_bench.sv
module mgmt_serial_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam logic [15:0] ID_VALUE = 16'h0610;
    localparam logic [5:0]  GEN_ADDR = 6'd1;
    localparam logic [5:0]  IMP_ADDR = 6'd2;

    logic clk = 1'b0;
    logic rst_n, ser_clk, ser_din, ser_stb_n;
    logic ser_dout, stop_hold, pulse_short;
    logic [7:0] imp_value;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [15:0] m_gen = '0;
    logic [7:0]  m_imp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_serial_slave u_mgmt_serial_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_din     (ser_din),
        .ser_stb_n   (ser_stb_n),
        .ser_dout    (ser_dout),
        .stop_hold   (stop_hold),
        .imp_value   (imp_value),
        .pulse_short (pulse_short)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic so);
        ser_din = b;
        wait_clk(HALF);
        so = ser_dout;
        ser_clk = 1'b1;
        wait_clk(HALF);
        ser_clk = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input logic [5:0] a);
        if (a == 6'd0)     return {ID_VALUE, 16'h0};
        if (a == GEN_ADDR) return {m_gen, 16'h0};
        if (a == IMP_ADDR) return {m_imp, 24'h0};
        return 32'h0;
    endfunction

    function automatic logic [31:0] top_mask(input int n);
        if (n >= 32) return 32'hFFFF_FFFF;
        return ~(32'hFFFF_FFFF >> n);
    endfunction

    task automatic xfer(input int pad, input logic wr, input logic [5:0] addr,
                        input logic [31:0] wdata, input int nbits,
                        output logic [31:0] rdata, output logic quiet);
        logic so;
        rdata = '0;
        quiet = 1'b1;
        ser_stb_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < pad; i++) send_bit(1'b0, so);
        send_bit(1'b1, so);
        send_bit(wr, so);
        for (int i = 5; i >= 0; i--) send_bit(addr[i], so);
        for (int i = 0; i < nbits; i++) begin
            send_bit(wr ? wdata[31-i] : 1'($urandom % 2), so);
            rdata[31-i] = so;
            if (wr && so) quiet = 1'b0;
        end
        wait_clk(HALF);
        ser_stb_n = 1'b1;
        wait_clk(3*HALF);
    endtask

    task automatic read_check(input int pad, input logic [5:0] addr, input int nbits, input string req);
        logic [31:0] rd;
        logic        q;
        logic [31:0] exp;
        xfer(pad, 1'b0, addr, 32'h0, nbits, rd, q);
        exp = exp_word(addr) & top_mask(nbits);
        check((rd & top_mask(nbits)) == exp, req, rd & top_mask(nbits), exp);
    endtask

    initial begin
        logic [31:0] rd;
        logic        q;
        logic [15:0] v16;
        logic [7:0]  v8;
        logic [5:0]  ua;
        logic        so;

        void'($urandom(32'd2024));
        rst_n = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; ser_stb_n = 1'b1;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1 reset state
        check(ser_dout == 1'b0,    "R1 dout",  32'(ser_dout), 0);
        check(stop_hold == 1'b0,   "R1 stop",  32'(stop_hold), 0);
        check(pulse_short == 1'b0, "R1 flag",  32'(pulse_short), 0);
        check(imp_value == 8'h00,  "R1 imp",   32'(imp_value), 0);

        // R4 R3 ID read, no padding
        read_check(0, 6'd0, 16, "R4 id read");
        // R2 leading zeros skipped, R3 zero fill past width
        read_check(8, 6'd0, 24, "R2 R3 padded id read");

        // R4 write to ID discarded
        xfer(0, 1'b1, 6'd0, 32'hFFFF_0000, 16, rd, q);
        check(q == 1'b1, "R5 dout quiet on id write", 32'(q), 1);
        read_check(0, 6'd0, 16, "R4 id after write");

        // R6 generic chain random round trips
        for (int n = 0; n < 6; n++) begin
            v16 = 16'($urandom);
            xfer(0, 1'b1, GEN_ADDR, {v16, 16'h0}, 16, rd, q);
            m_gen = v16;
            check(q == 1'b1, "R5 dout quiet on write", 32'(q), 1);
            check(stop_hold == 1'b0, "R10 no stop on generic write", 32'(stop_hold), 0);
            read_check((n % 2) * 8, GEN_ADDR, 16, "R6 generic readback");
        end

        // R5 longer write keeps last bits
        v16 = 16'($urandom);
        xfer(0, 1'b1, GEN_ADDR, {8'hA5, v16, 8'h00}, 24, rd, q);
        m_gen = v16;
        read_check(0, GEN_ADDR, 20, "R5 last bits kept, R3 zero tail");

        // R7 unused address
        ua = 6'd3 + 6'($urandom % 61);
        xfer(0, 1'b1, ua, 32'hDEAD_BEEF, 16, rd, q);
        read_check(0, ua, 16, "R7 unused reads zero");
        read_check(0, GEN_ADDR, 16, "R7 unused write no effect");

        // R8 abort before full command
        ser_stb_n = 1'b0;
        wait_clk(HALF);
        send_bit(1'b1, so); send_bit(1'b1, so);
        send_bit(1'b0, so); send_bit(1'b0, so); send_bit(1'b0, so);
        wait_clk(HALF);
        ser_stb_n = 1'b1;
        wait_clk(3*HALF);
        read_check(0, GEN_ADDR, 16, "R8 abort no change");

        // R9 impedance guarded update
        v8 = 8'($urandom);
        if (v8 == m_imp) v8 = ~v8;
        xfer(0, 1'b1, IMP_ADDR, {v8, 24'h0}, 8, rd, q);
        check(stop_hold == 1'b1, "R9 stop after imp write", 32'(stop_hold), 1);
        check(imp_value == m_imp, "R9 imp held", 32'(imp_value), 32'(m_imp));
        ser_stb_n = 1'b0;
        wait_clk(3*HALF);
        m_imp = v8;
        check(imp_value == m_imp, "R9 imp applied", 32'(imp_value), 32'(m_imp));
        check(stop_hold == 1'b1, "R9 stop held while applied", 32'(stop_hold), 1);
        ser_stb_n = 1'b1;
        wait_clk(3*HALF);
        check(stop_hold == 1'b0, "R9 stop released", 32'(stop_hold), 0);
        read_check(0, IMP_ADDR, 8, "R9 imp readback");

        // R11 timing flag
        check(pulse_short == 1'b0, "R11 no flag on legal pulses", 32'(pulse_short), 0);
        ser_stb_n = 1'b0;
        wait_clk(4);
        ser_stb_n = 1'b1;
        wait_clk(3*HALF);
        check(pulse_short == 1'b1, "R11 short pulse flagged", 32'(pulse_short), 1);
        check(stop_hold == 1'b0, "R10 stop stays low", 32'(stop_hold), 0);
        read_check(0, 6'd0, 16, "R3 read after flag");
        check(pulse_short == 1'b1, "R11 flag sticky", 32'(pulse_short), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule